// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer with Gated Serial Readout

This block is the digital side of a 14-bit successive-approximation converter. A one-cycle start request, sampled on the externally supplied conversion clock, opens a conversion window. While the window is open, the busy output is low. On each conversion-clock edge in the window the block tests one trial bit against the comparator decision, working from the top bit down. When the last bit has been decided, the code is latched and busy rises again. That rising edge tells the host the result is ready.

The host reads the latched code serially. It pulls the read strobe low and supplies a serial clock. The data pin is driven only while the strobe is low. The top bit is presented first and each falling serial edge advances one position. Once all fourteen bits have gone out, the pin drives zeros for every further clock, so a 16-clock word ends in two zero bits. The serial clock and the conversion clock are independent. A finished code is handed into the serial domain by a toggle flag that passes through a two-stage synchronizer. It is copied into a read buffer only while no read is in progress.

Top module: `sar_readout`

## Requirements
- R1: A high `conv_start` sampled on a rising `conv_clk` edge while `busy` is high starts a conversion, and `busy` is low right after that edge.
- R2: `busy` stays low for exactly 14 `conv_clk` cycles. It rises on the 14th rising edge after the start edge, and that rise marks a completed result.
- R3: Right after the start edge, `dac_code` holds only bit 13 set (0x2000). On each edge in the window, the bit under test is kept if `cmp_in` is 1 and cleared if it is 0, and the next lower bit is set for trial. The result is the code made of these decisions, bit 13 first and bit 0 last.
- R4: `conv_start` is ignored while `busy` is low. The window length and the result are unchanged.
- R5: While `rd_n` is low, `sdo` shows result bit 13 from the moment the strobe falls. Each falling `sclk` edge advances to the next lower bit, so the first 14 clocks carry bits 13 down to 0.
- R6: After bit 0, `sdo` is 0 for every further `sclk` cycle of the same read, including clocks 15 and 16 and any clocks beyond them.
- R7: `sdo_oe` is 1 exactly while `rd_n` is low. While `rd_n` is high, `sdo` is high-impedance.
- R8: `sclk` edges have no effect on the bit position while `rd_n` is high. Raising `rd_n` returns the position to bit 13, so a read that follows a partial read starts again from bit 13.
- R9: A read started after three rising `sclk` edges with `rd_n` high, counted from the rise of `busy`, returns the new result.
- R10: A read in progress keeps the code it started with for its whole length, even if a new conversion completes during the read. The new code becomes readable once `rd_n` has been high for three rising `sclk` edges.
- R11: `sdo` changes only on falling `sclk` edges and holds its value through each high phase.
- R12: After reset, `busy` is 1, `dac_code` is 0 and the stored result reads as all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| conv_clk | input | 1 | External conversion clock; one bit test per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset for both clock domains |
| conv_start | input | 1 | Conversion request, sampled on rising `conv_clk` |
| cmp_in | input | 1 | Comparator decision for the current trial code (1 = keep bit) |
| busy | output | 1 | Low during a conversion; rising edge marks completion |
| dac_code | output | 14 | Trial code presented to the converter's DAC |
| sclk | input | 1 | Host serial clock |
| rd_n | input | 1 | Active-low read strobe; gates `sclk` and enables `sdo` |
| sdo | output | 1 | Serial data, tri-stated when not reading |
| sdo_oe | output | 1 | Output-enable state of `sdo` |

## Verification
`busy` must be low at the first falling `conv_clk` edge after the start edge. The bench counts falling edges until `busy` returns high and expects exactly 14. The trial code is due one edge after the start request, so it is sampled on the following falling edge. A new result is due in the serial domain three rising `sclk` edges after `busy` rises. The bench waits exactly that many before it lowers the strobe. Each serial bit is sampled twice within the high phase: 2 ns and 6 ns after the rising `sclk` edge. This keeps every sample clear of the falling edge on which the data may change, and it lets the bench confirm that each bit holds through the whole phase.

// File: rtl/sar_pkg.sv
`timescale 1ns/1ps
package sar_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_CONV = 1'b1
    } conv_st_e;
endpackage

// File: rtl/sar_seq.sv
`timescale 1ns/1ps
// Conversion-clock domain: start/busy handshake, bit-test sequencer, result latch.
module sar_seq
    import sar_pkg::*;
#(
    parameter int DATA_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              cmp_in,
    output logic              busy,
    output logic [DATA_W-1:0] dac_code,
    output logic [DATA_W-1:0] result,
    output logic              done_tgl
);
    localparam int IDX_W = $clog2(DATA_W);
    localparam logic [DATA_W-1:0] TOP_TRIAL = {1'b1, {(DATA_W-1){1'b0}}};

    typedef struct packed {
        conv_st_e          st;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] trial;
        logic [DATA_W-1:0] result;
        logic              tgl;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        case (seq_q.st)
            ST_IDLE: begin
                if (start) begin
                    seq_d.st    = ST_CONV;
                    seq_d.idx   = IDX_W'(DATA_W - 1);
                    seq_d.trial = TOP_TRIAL;
                end
            end
            default: begin
                if (!cmp_in) begin
                    seq_d.trial[seq_q.idx] = 1'b0;
                end
                if (seq_q.idx == '0) begin
                    seq_d.st     = ST_IDLE;
                    seq_d.result = seq_d.trial;
                    seq_d.tgl    = ~seq_q.tgl;
                end else begin
                    seq_d.idx              = seq_q.idx - 1'b1;
                    seq_d.trial[seq_d.idx] = 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: ST_IDLE, idx: '0, trial: '0, result: '0, tgl: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy     = (seq_q.st == ST_IDLE);
    assign dac_code = seq_q.trial;
    assign result   = seq_q.result;
    assign done_tgl = seq_q.tgl;

    AST_START_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(start)); // R1
    AST_MSB_TRIAL: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (dac_code == TOP_TRIAL)); // R3
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && busy) |-> $stable(result)); // R4
endmodule

// File: rtl/sar_sync.sv
`timescale 1ns/1ps
// Multi-stage synchronizer for a single level/toggle signal.
module sar_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] pipe_d, pipe_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb pipe_d = d;
        end else begin : g_chain
            always_comb pipe_d = {pipe_q[STAGES-2:0], d};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/sar_shift.sv
`timescale 1ns/1ps
// Serial-clock domain: read buffer load, bit position, zero fill, output enable.
module sar_shift #(
    parameter int DATA_W = 14
) (
    input  logic              sclk,
    input  logic              rst_n,
    input  logic              rd_n,
    input  logic              ready_tgl,
    input  logic [DATA_W-1:0] result,
    output logic              sdo_bit,
    output logic              sdo_oe
);
    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] FILL_POS = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] TOP_POS  = CNT_W'(DATA_W - 1);

    typedef struct packed {
        logic              seen;
        logic [DATA_W-1:0] shadow;
    } hold_t;

    hold_t hold_d, hold_q;
    logic [CNT_W-1:0] pos_d, pos_q;

    // Buffer load: only while no read is in progress
    always_comb begin
        hold_d = hold_q;
        if (rd_n && (ready_tgl != hold_q.seen)) begin
            hold_d.seen   = ready_tgl;
            hold_d.shadow = result;
        end
    end

    always_ff @(posedge sclk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else begin
            hold_q <= hold_d;
        end
    end

    // Bit position: advances on falling sclk, saturates in zero fill
    always_comb begin
        pos_d = (pos_q == FILL_POS) ? pos_q : pos_q + 1'b1;
    end

    always_ff @(negedge sclk or negedge rst_n or posedge rd_n) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else if (rd_n) begin
            pos_q <= '0;
        end else begin
            pos_q <= pos_d;
        end
    end

    assign sdo_bit = (pos_q < FILL_POS) ? hold_q.shadow[TOP_POS - pos_q] : 1'b0;
    assign sdo_oe  = ~rd_n;

    AST_BUFFER_FROZEN: assert property (@(posedge sclk) disable iff (!rst_n)
        (!rd_n && $past(!rd_n)) |-> $stable(hold_q.shadow)); // R10
    AST_FILL_STAYS: assert property (@(negedge sclk) disable iff (!rst_n || rd_n)
        (pos_q == FILL_POS) |=> (pos_q == FILL_POS)); // R6
endmodule

// File: rtl/sar_readout.sv
`timescale 1ns/1ps
// Top: conversion sequencer, clock-domain handover, serial readout.
module sar_readout #(
    parameter int DATA_W      = 14,
    parameter int SYNC_STAGES = 2
) (
    input  logic              conv_clk,
    input  logic              rst_n,
    input  logic              conv_start,
    input  logic              cmp_in,
    output logic              busy,
    output logic [DATA_W-1:0] dac_code,
    input  logic              sclk,
    input  logic              rd_n,
    output logic              sdo,
    output logic              sdo_oe
);
    logic [DATA_W-1:0] result;
    logic              done_tgl;
    logic              ready_tgl;
    logic              sdo_bit;

    sar_seq #(.DATA_W(DATA_W)) u_seq (
        .clk      (conv_clk),
        .rst_n    (rst_n),
        .start    (conv_start),
        .cmp_in   (cmp_in),
        .busy     (busy),
        .dac_code (dac_code),
        .result   (result),
        .done_tgl (done_tgl)
    );

    sar_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (sclk),
        .rst_n (rst_n),
        .d     (done_tgl),
        .q     (ready_tgl)
    );

    sar_shift #(.DATA_W(DATA_W)) u_shift (
        .sclk      (sclk),
        .rst_n     (rst_n),
        .rd_n      (rd_n),
        .ready_tgl (ready_tgl),
        .result    (result),
        .sdo_bit   (sdo_bit),
        .sdo_oe    (sdo_oe)
    );

    assign sdo = sdo_oe ? sdo_bit : 1'bz;
endmodule

// File: tb/sar_readout_bench.sv
`timescale 1ns/1ps
module sar_readout_bench;
    logic        conv_clk = 1'b0;
    logic        sclk     = 1'b0;
    logic        rst_n    = 1'b0;
    logic        conv_start = 1'b0;
    logic        rd_n     = 1'b1;
    logic [13:0] target   = '0;
    logic        busy;
    logic [13:0] dac_code;
    logic        sdo_oe;
    wire         sdo;
    logic        cmp_in;
    int          checks = 0;
    int          errors = 0;
    bit          finished = 1'b0;

    assign cmp_in = (dac_code <= target);

    always #2.5 conv_clk = ~conv_clk;   // 200 MHz
    always #7   sclk     = ~sclk;

    sar_readout u_sar_readout (
        .conv_clk   (conv_clk),
        .rst_n      (rst_n),
        .conv_start (conv_start),
        .cmp_in     (cmp_in),
        .busy       (busy),
        .dac_code   (dac_code),
        .sclk       (sclk),
        .rd_n       (rd_n),
        .sdo        (sdo),
        .sdo_oe     (sdo_oe)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_convert(input logic [13:0] v, input bit restart, input string req);
        int lows = 0;
        target = v;
        @(negedge conv_clk); conv_start = 1'b1;
        @(negedge conv_clk); conv_start = 1'b0;
        chk(busy == 1'b0, "R1", "busy after start edge", 32'(busy), 32'd0);
        chk(dac_code == 14'h2000, "R3", "first trial code", 32'(dac_code), 32'h2000);
        for (int i = 0; i < 40 && !busy; i++) begin
            lows++;
            if (restart && i == 4) conv_start = 1'b1;
            if (restart && i == 5) conv_start = 1'b0;
            @(negedge conv_clk);
        end
        chk(lows == 14, req, "busy low cycles", 32'(lows), 32'd14);
    endtask

    task automatic read_word(input logic [13:0] exp, input int nclk, input string req);
        int bad = 0;
        int unstable = 0;
        logic a, b, e;
        @(negedge sclk); #2 rd_n = 1'b0;
        #2 chk(sdo_oe == 1'b1 && sdo == exp[13], "R5", "first bit at strobe",
               32'({sdo_oe, sdo}), 32'({1'b1, exp[13]}));
        for (int k = 0; k < nclk; k++) begin
            @(posedge sclk);
            #2 a = sdo;
            #4 b = sdo;
            e = (k < 14) ? exp[13 - k] : 1'b0;
            if (a !== e) bad++;
            if (a !== b) unstable++;
        end
        chk(bad == 0, req, "wrong serial bits", 32'(bad), 32'd0);
        chk(unstable == 0, "R11", "bit changed in high phase", 32'(unstable), 32'd0);
        @(negedge sclk); #2 rd_n = 1'b1;
        #1 chk(sdo_oe == 1'b0, "R7", "enable after release", 32'(sdo_oe), 32'd0);
    endtask

    task automatic t_reset();
        repeat (4) @(negedge conv_clk);
        chk(busy == 1'b1, "R12", "busy in reset", 32'(busy), 32'd1);
        chk(dac_code == 14'h0, "R12", "dac code in reset", 32'(dac_code), 32'd0);
        chk(sdo_oe == 1'b0, "R7", "enable before read", 32'(sdo_oe), 32'd0);
        rst_n = 1'b1;
        repeat (3) @(posedge sclk);
        read_word(14'h0, 16, "R12");
    endtask

    task automatic t_basic();
        do_convert(14'h2A5C, 1'b0, "R2");
        repeat (3) @(posedge sclk);   // R9 handover window
        read_word(14'h2A5C, 16, "R9");
        read_word(14'h2A5C, 22, "R6");
    endtask

    task automatic t_extremes();
        do_convert(14'h0000, 1'b0, "R2");
        repeat (3) @(posedge sclk);
        read_word(14'h0000, 16, "R3");
        do_convert(14'h3FFF, 1'b0, "R2");
        repeat (3) @(posedge sclk);
        read_word(14'h3FFF, 16, "R3");
    endtask

    task automatic t_restart();
        do_convert(14'h155A, 1'b1, "R4");
        repeat (3) @(posedge sclk);
        read_word(14'h155A, 16, "R4");
    endtask

    task automatic t_partial();
        read_word(14'h155A, 5, "R8");
        repeat (6) @(posedge sclk);   // sclk runs with strobe high
        read_word(14'h155A, 16, "R8");
    endtask

    task automatic t_read_during_conv();
        target = 14'h0F0F;
        @(negedge conv_clk); conv_start = 1'b1;
        @(negedge conv_clk); conv_start = 1'b0;
        read_word(14'h155A, 16, "R10");
        chk(busy == 1'b1, "R2", "busy after overlap", 32'(busy), 32'd1);
        repeat (3) @(posedge sclk);
        read_word(14'h0F0F, 16, "R10");
    endtask

    initial begin
        t_reset();
        t_basic();
        t_extremes();
        t_restart();
        t_partial();
        t_read_during_conv();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #400us;
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog all-requirements actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule